// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a parallel NOR flash. It takes one request at a time: a byte program, a sector erase or a chip erase. It sends the standard unlock and command write sequence on the flash bus. Every bus access uses fixed setup, strobe and hold cycle counts, which are parameters. After the last command write, the block reads the target address again and again until the device reports that the embedded operation has finished.

Two ways of polling are supported. In data-poll mode the block watches bit 7 of each status read. In toggle mode it compares bit 6 between consecutive reads. Whichever mode is used, the block then makes one further full read of the target byte. It compares that byte with the expected value, which is the written byte for a program and 0xFF for an erase. The block then returns exactly one single-cycle response, carrying the request's tag: done, error or timeout. A cycle counter limits the polling time. The program limit and the erase limit are separate parameters.

Top module: `flash_op_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1. fl_ce_n, fl_we_n and fl_oe_n are all 1, fl_dq_oe is 0, and no response output is high.
- R2: A program request (req_op = 0) issues four writes in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the target address with the request data.
- R3: An erase request issues six writes. The first five are 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA and 0x2AA/0x55. The sixth is the target address with 0x30 for a sector erase (req_op = 1), or 0x555/0x10 for a chip erase (req_op = 2 or 3).
- R4: In every bus access, chip enable is low for SETUP_CYC + PULSE_CYC + HOLD_CYC cycles and the strobe is low for exactly PULSE_CYC cycles. Chip enable returns high between accesses, so each poll read is a separate access. Write enable and output enable are never low together. The data bus is driven only during write accesses, and the address stays stable while a strobe is low.
- R5: No status read starts before the final command write has completed. Every status read and the final read use the request address.
- R6: In data-poll mode (req_mode = 0), polling ends at the first read whose bit 7 equals bit 7 of the expected value, and exactly one further read follows. For a program with B busy reads, this gives B + 2 reads in total.
- R7: In toggle mode (req_mode = 1), bit 7 of the status reads is ignored. Polling continues while bit 6 differs between consecutive reads and ends once two consecutive reads agree. One further read then follows.
- R8: The final read is compared with the expected value (the request data for a program, 0xFF for an erase). If it matches, rsp_done pulses; if not, rsp_error pulses. Each pulse lasts one cycle and carries the request's tag on rsp_tag.
- R9: If completion has not been seen once the poll counter reaches PROG_LIMIT (program) or ERASE_LIMIT (erase) cycles, rsp_timeout pulses with the tag and no done or error is given. The next request then works normally.
- R10: A request is accepted when req_valid and req_ready are both high. req_ready is low from the next cycle until the response. Each request gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| req_mode | input | 1 | 0 data-poll on bit 7, 1 toggle on bit 6 |
| req_addr | input | AW | Target byte / sector address, also the poll address |
| req_data | input | 8 | Byte to program |
| req_tag | input | TAGW | Tag returned with the response |
| rsp_done | output | 1 | Operation finished and verified (one cycle) |
| rsp_error | output | 1 | Final read mismatch (one cycle) |
| rsp_timeout | output | 1 | Poll limit exceeded (one cycle) |
| rsp_tag | output | TAGW | Tag of the answered request |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Host drives the flash data bus |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
The assertions take for granted that the requester presents only one request at a time and keeps the request fields stable while req_valid is high. They also take for granted that the flash returns a settled byte on fl_rdata for the whole read strobe. The stimulus respects both of these. It drives each request at a falling clock edge and waits for the response before sending the next one. The flash model in the bench changes its read data only on the falling edge of output enable. That model gives a set number of busy reads, then one race read in which bit 7 already shows completion but the low bits are still wrong, and then the stored byte. It can also report bit 7 falsely, corrupt the stored byte, or stay busy for ever.

// File: rtl/fop_pkg.sv
package fop_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_CHIP_ALT = 2'd3
    } fop_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD_GO,
        S_CMD_WAIT,
        S_POLL_GO,
        S_POLL_WAIT,
        S_FIN_GO,
        S_FIN_WAIT
    } fop_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } fop_phase_e;

    localparam int unsigned FOP_DW = 8;

endpackage

// File: rtl/fop_bus_cycle.sv
module fop_bus_cycle
    import fop_pkg::*;
#(
    parameter int unsigned AW        = 19,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned PULSE_CYC = 3,
    parameter int unsigned HOLD_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_wr,
    input  logic [AW-1:0]     addr,
    input  logic [FOP_DW-1:0] wdata,
    output logic              done,
    output logic [FOP_DW-1:0] rdata,
    output logic [AW-1:0]     fl_addr,
    output logic [FOP_DW-1:0] fl_wdata,
    output logic              fl_dq_oe,
    input  logic [FOP_DW-1:0] fl_rdata,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int unsigned MAXC = (SETUP_CYC > PULSE_CYC)
                                 ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                                 : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int unsigned CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SETUP_END = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_END  = CW'(HOLD_CYC - 1);

    typedef struct packed {
        fop_phase_e        phase;
        logic [CW-1:0]     cnt;
        logic              is_wr;
        logic [AW-1:0]     addr;
        logic [FOP_DW-1:0] wdata;
        logic [FOP_DW-1:0] rdata;
    } bus_t;

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d = bus_q;
        done  = 1'b0;
        unique case (bus_q.phase)
            PH_IDLE: begin
                if (start) begin
                    bus_d.phase = PH_SETUP;
                    bus_d.cnt   = '0;
                    bus_d.is_wr = is_wr;
                    bus_d.addr  = addr;
                    bus_d.wdata = wdata;
                end
            end
            PH_SETUP: begin
                if (bus_q.cnt == SETUP_END) begin
                    bus_d.phase = PH_STROBE;
                    bus_d.cnt   = '0;
                end else begin
                    bus_d.cnt = bus_q.cnt + 1'b1;
                end
            end
            PH_STROBE: begin
                if (bus_q.cnt == PULSE_END) begin
                    if (!bus_q.is_wr) begin
                        bus_d.rdata = fl_rdata;
                    end
                    bus_d.phase = PH_HOLD;
                    bus_d.cnt   = '0;
                end else begin
                    bus_d.cnt = bus_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (bus_q.cnt == HOLD_END) begin
                    bus_d.phase = PH_IDLE;
                    bus_d.cnt   = '0;
                    done        = 1'b1;
                end else begin
                    bus_d.cnt = bus_q.cnt + 1'b1;
                end
            end
            default: bus_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            bus_q <= bus_d;
        end
    end

    assign rdata    = bus_q.rdata;
    assign fl_addr  = bus_q.addr;
    assign fl_wdata = bus_q.wdata;
    assign fl_ce_n  = (bus_q.phase == PH_IDLE);
    assign fl_we_n  = !((bus_q.phase == PH_STROBE) && bus_q.is_wr);
    assign fl_oe_n  = !((bus_q.phase == PH_STROBE) && !bus_q.is_wr);
    assign fl_dq_oe = bus_q.is_wr && (bus_q.phase != PH_IDLE);

endmodule

// File: rtl/fop_cmd_seq.sv
module fop_cmd_seq
    import fop_pkg::*;
#(
    parameter int unsigned AW       = 19,
    parameter int unsigned UNLOCK_A = 'h555,
    parameter int unsigned UNLOCK_B = 'h2AA
) (
    input  fop_op_e           op,
    input  logic [2:0]        step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [FOP_DW-1:0] tgt_data,
    output logic [AW-1:0]     cmd_addr,
    output logic [FOP_DW-1:0] cmd_data,
    output logic              cmd_last
);

    localparam logic [AW-1:0] ADR_A = AW'(UNLOCK_A);
    localparam logic [AW-1:0] ADR_B = AW'(UNLOCK_B);

    logic is_prog;
    assign is_prog = (op == OP_PROG);

    always_comb begin
        cmd_addr = ADR_A;
        cmd_data = 8'hAA;
        cmd_last = 1'b0;
        unique case (step)
            3'd0: begin cmd_addr = ADR_A; cmd_data = 8'hAA; end
            3'd1: begin cmd_addr = ADR_B; cmd_data = 8'h55; end
            3'd2: begin cmd_addr = ADR_A; cmd_data = is_prog ? 8'hA0 : 8'h80; end
            3'd3: begin
                if (is_prog) begin
                    cmd_addr = tgt_addr;
                    cmd_data = tgt_data;
                    cmd_last = 1'b1;
                end else begin
                    cmd_addr = ADR_A;
                    cmd_data = 8'hAA;
                end
            end
            3'd4: begin cmd_addr = ADR_B; cmd_data = 8'h55; end
            default: begin
                cmd_last = 1'b1;
                if (op == OP_SECT) begin
                    cmd_addr = tgt_addr;
                    cmd_data = 8'h30;
                end else begin
                    cmd_addr = ADR_A;
                    cmd_data = 8'h10;
                end
            end
        endcase
    end

endmodule

// File: rtl/fop_timer.sv
module fop_timer #(
    parameter int unsigned CNTW = 18
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [CNTW-1:0] limit,
    output logic            expired
);

    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && (cnt_q != {CNTW{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q >= limit);

endmodule

// File: rtl/flash_op_poller.sv
module flash_op_poller
    import fop_pkg::*;
#(
    parameter int unsigned AW          = 19,
    parameter int unsigned TAGW        = 4,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned PULSE_CYC   = 3,
    parameter int unsigned HOLD_CYC    = 1,
    parameter int unsigned PROG_LIMIT  = 2000,
    parameter int unsigned ERASE_LIMIT = 200000,
    parameter int unsigned UNLOCK_A    = 'h555,
    parameter int unsigned UNLOCK_B    = 'h2AA
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic            req_mode,
    input  logic [AW-1:0]   req_addr,
    input  logic [7:0]      req_data,
    input  logic [TAGW-1:0] req_tag,
    output logic            rsp_done,
    output logic            rsp_error,
    output logic            rsp_timeout,
    output logic [TAGW-1:0] rsp_tag,
    output logic [AW-1:0]   fl_addr,
    output logic [7:0]      fl_wdata,
    output logic            fl_dq_oe,
    input  logic [7:0]      fl_rdata,
    output logic            fl_ce_n,
    output logic            fl_we_n,
    output logic            fl_oe_n
);

    localparam int unsigned LIM_MAX = (PROG_LIMIT > ERASE_LIMIT) ? PROG_LIMIT : ERASE_LIMIT;
    localparam int unsigned TMW     = $clog2(LIM_MAX + 2);
    localparam logic [TMW-1:0] PROG_LIM_V  = TMW'(PROG_LIMIT);
    localparam logic [TMW-1:0] ERASE_LIM_V = TMW'(ERASE_LIMIT);

    typedef struct packed {
        fop_state_e        st;
        logic [2:0]        step;
        fop_op_e           op;
        logic              mode;
        logic [AW-1:0]     addr;
        logic [FOP_DW-1:0] data;
        logic [TAGW-1:0]   tag;
        logic              have_prev;
        logic              prev6;
        logic              done;
        logic              err;
        logic              tmo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              bus_start, bus_is_wr, bus_done;
    logic [AW-1:0]     bus_addr;
    logic [FOP_DW-1:0] bus_wdata, bus_rdata;
    logic [AW-1:0]     cmd_addr;
    logic [FOP_DW-1:0] cmd_data;
    logic              cmd_last;
    logic              tm_clear, tm_run, tm_expired;
    logic [TMW-1:0]    tm_limit;
    logic [FOP_DW-1:0] exp_byte;
    logic              hit;

    fop_cmd_seq #(
        .AW(AW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
    ) u_seq (
        .op(ctl_q.op), .step(ctl_q.step),
        .tgt_addr(ctl_q.addr), .tgt_data(ctl_q.data),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last)
    );

    fop_bus_cycle #(
        .AW(AW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n),
        .start(bus_start), .is_wr(bus_is_wr), .addr(bus_addr), .wdata(bus_wdata),
        .done(bus_done), .rdata(bus_rdata),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_dq_oe(fl_dq_oe),
        .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    fop_timer #(.CNTW(TMW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tm_clear), .run(tm_run),
        .limit(tm_limit), .expired(tm_expired)
    );

    assign exp_byte = (ctl_q.op == OP_PROG) ? ctl_q.data : 8'hFF;
    assign tm_limit = (ctl_q.op == OP_PROG) ? PROG_LIM_V : ERASE_LIM_V;
    assign tm_run   = (ctl_q.st == S_POLL_GO) || (ctl_q.st == S_POLL_WAIT);

    // Completion test for one status read, chosen by polling mode
    always_comb begin
        if (ctl_q.mode) begin
            hit = ctl_q.have_prev && (bus_rdata[6] == ctl_q.prev6);
        end else begin
            hit = (bus_rdata[7] == exp_byte[7]);
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.err  = 1'b0;
        ctl_d.tmo  = 1'b0;
        bus_start  = 1'b0;
        bus_is_wr  = 1'b0;
        bus_addr   = ctl_q.addr;
        bus_wdata  = cmd_data;
        tm_clear   = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    ctl_d.st   = S_CMD_GO;
                    ctl_d.step = '0;
                    ctl_d.op   = fop_op_e'(req_op);
                    ctl_d.mode = req_mode;
                    ctl_d.addr = req_addr;
                    ctl_d.data = req_data;
                    ctl_d.tag  = req_tag;
                end
            end
            S_CMD_GO: begin
                bus_start = 1'b1;
                bus_is_wr = 1'b1;
                bus_addr  = cmd_addr;
                ctl_d.st  = S_CMD_WAIT;
            end
            S_CMD_WAIT: begin
                if (bus_done) begin
                    if (cmd_last) begin
                        ctl_d.st        = S_POLL_GO;
                        ctl_d.have_prev = 1'b0;
                        tm_clear        = 1'b1;
                    end else begin
                        ctl_d.step = ctl_q.step + 1'b1;
                        ctl_d.st   = S_CMD_GO;
                    end
                end
            end
            S_POLL_GO: begin
                bus_start = 1'b1;
                ctl_d.st  = S_POLL_WAIT;
            end
            S_POLL_WAIT: begin
                if (bus_done) begin
                    ctl_d.have_prev = 1'b1;
                    ctl_d.prev6     = bus_rdata[6];
                    if (hit) begin
                        ctl_d.st = S_FIN_GO;
                    end else if (tm_expired) begin
                        ctl_d.st  = S_IDLE;
                        ctl_d.tmo = 1'b1;
                    end else begin
                        ctl_d.st = S_POLL_GO;
                    end
                end
            end
            S_FIN_GO: begin
                bus_start = 1'b1;
                ctl_d.st  = S_FIN_WAIT;
            end
            S_FIN_WAIT: begin
                if (bus_done) begin
                    ctl_d.st = S_IDLE;
                    if (bus_rdata == exp_byte) begin
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: S_IDLE, op: OP_PROG, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == S_IDLE);
    assign rsp_done    = ctl_q.done;
    assign rsp_error   = ctl_q.err;
    assign rsp_timeout = ctl_q.tmo;
    assign rsp_tag     = ctl_q.tag;

endmodule

// File: rtl/fop_checker.sv
module fop_checker #(
    parameter int unsigned AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          rsp_error,
    input logic          rsp_timeout,
    input logic [AW-1:0] fl_addr,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n
);

    logic rsp_any;
    assign rsp_any = rsp_done | rsp_error | rsp_timeout;

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    p_ce_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);

    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_dq_oe |-> fl_oe_n);

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |=> ((fl_we_n && fl_oe_n) || $stable(fl_addr)));

    p_rsp_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_done, rsp_error, rsp_timeout}));

    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_any |=> !rsp_any);

    p_idle_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> fl_ce_n);

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind flash_op_poller fop_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_timeout(rsp_timeout),
    .fl_addr(fl_addr), .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/sim_flash_op_poller.sv
module sim_flash_op_poller;

    localparam int AW = 19;
    localparam int SU = 2;
    localparam int PW = 3;
    localparam int HD = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic          req_mode = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [3:0]    req_tag = '0;
    logic          rsp_done, rsp_error, rsp_timeout;
    logic [3:0]    rsp_tag;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic          fl_dq_oe;
    logic [7:0]    fl_rdata = 8'h00;
    logic          fl_ce_n, fl_we_n, fl_oe_n;

    flash_op_poller #(
        .AW(AW), .TAGW(4), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
        .PROG_LIMIT(300), .ERASE_LIMIT(900)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
        .req_tag(req_tag), .rsp_done(rsp_done), .rsp_error(rsp_error),
        .rsp_timeout(rsp_timeout), .rsp_tag(rsp_tag), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_dq_oe(fl_dq_oe), .fl_rdata(fl_rdata),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    // Scoreboard queues
    logic [AW-1:0] wq_addr[$];
    logic [7:0]    wq_data[$];
    string         wq_rq[$];
    int            rq_kind[$];
    logic [3:0]    rq_tag[$];
    string         rq_rq[$];

    // Flash model state
    int            m_nwr = 0, m_wr = 0, m_rd = 0, m_busy = 0;
    bit            m_forever = 0, m_lie = 0, m_race = 0, m_tog = 0, m_cmd_done = 0;
    logic [7:0]    m_stored = 8'h00, m_exp = 8'h00;
    logic [AW-1:0] m_paddr = '0;

    // Write monitor: command sequence (R2, R3)
    always @(posedge fl_we_n) begin
        if (rst_n) begin
            m_wr++;
            if (m_wr == m_nwr) m_cmd_done = 1;
            if (wq_addr.size() == 0) begin
                check(0, "R2", "unexpected write", fl_addr, 0);
            end else begin
                automatic logic [AW-1:0] ea = wq_addr.pop_front();
                automatic logic [7:0] ed = wq_data.pop_front();
                automatic string r = wq_rq.pop_front();
                check(fl_addr == ea, r, "write address", fl_addr, ea);
                check(fl_wdata == ed, r, "write data", fl_wdata, ed);
            end
        end
    end

    // Read model (R5, R6, R7)
    always @(negedge fl_oe_n) begin
        if (rst_n) begin
            m_rd++;
            if (!m_cmd_done) check(0, "R5", "read before last command write", m_wr, m_nwr);
            if (fl_addr != m_paddr) check(0, "R5", "poll address", fl_addr, m_paddr);
            if (m_forever || m_busy > 0) begin
                if (m_busy > 0) m_busy--;
                m_tog = ~m_tog;
                fl_rdata = {(m_lie ? m_exp[7] : ~m_exp[7]), m_tog, 6'b101010};
            end else if (m_race) begin
                m_race = 0;
                fl_rdata = {m_exp[7], ~m_stored[6:0]};
            end else begin
                fl_rdata = m_stored;
            end
        end
    end

    // Response monitor (R8, R9, R10)
    always @(negedge clk) begin
        if (rst_n && (rsp_done || rsp_error || rsp_timeout)) begin
            automatic int k = rsp_done ? 0 : (rsp_error ? 1 : 2);
            if (rq_kind.size() == 0) begin
                check(0, "R10", "response without request", k, 0);
            end else begin
                automatic int ek = rq_kind.pop_front();
                automatic logic [3:0] et = rq_tag.pop_front();
                automatic string r = rq_rq.pop_front();
                check(k == ek, r, "response kind", k, ek);
                check(rsp_tag == et, r, "response tag", rsp_tag, et);
            end
        end
    end

    // Strobe and enable widths (R4)
    int lo_cnt = 0, ce_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n || !fl_oe_n) lo_cnt++;
            else if (lo_cnt != 0) begin
                check(lo_cnt == PW, "R4", "strobe width", lo_cnt, PW);
                lo_cnt = 0;
            end
            if (!fl_ce_n) ce_cnt++;
            else if (ce_cnt != 0) begin
                check(ce_cnt == SU + PW + HD, "R4", "chip enable width", ce_cnt, SU + PW + HD);
                ce_cnt = 0;
            end
        end
    end

    task automatic push_wr(input logic [AW-1:0] a, input logic [7:0] d, input string r);
        wq_addr.push_back(a);
        wq_data.push_back(d);
        wq_rq.push_back(r);
    endtask

    // kind: 0 done, 1 error, 2 timeout
    task automatic run_op(input logic [1:0] op, input logic mode, input logic [AW-1:0] a,
                          input logic [7:0] d, input logic [3:0] tag, input int busy,
                          input bit forever_b, input bit lie, input bit corrupt,
                          input int kind, input string rq);
        automatic logic [7:0] ex = (op == 2'd0) ? d : 8'hFF;
        m_nwr = (op == 2'd0) ? 4 : 6;
        m_wr = 0; m_rd = 0; m_busy = busy; m_forever = forever_b; m_lie = lie;
        m_race = 1; m_tog = 0; m_cmd_done = 0; m_exp = ex; m_paddr = a;
        m_stored = corrupt ? (ex ^ 8'h01) : ex;
        push_wr(19'h555, 8'hAA, (op == 2'd0) ? "R2" : "R3");
        push_wr(19'h2AA, 8'h55, (op == 2'd0) ? "R2" : "R3");
        if (op == 2'd0) begin
            push_wr(19'h555, 8'hA0, "R2");
            push_wr(a, d, "R2");
        end else begin
            push_wr(19'h555, 8'h80, "R3");
            push_wr(19'h555, 8'hAA, "R3");
            push_wr(19'h2AA, 8'h55, "R3");
            if (op == 2'd1) push_wr(a, 8'h30, "R3");
            else            push_wr(19'h555, 8'h10, "R3");
        end
        rq_kind.push_back(kind);
        rq_tag.push_back(tag);
        rq_rq.push_back(rq);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mode = mode;
        req_addr = a; req_data = d; req_tag = tag;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R10", "ready low after accept", req_ready, 0);
        while (rq_kind.size() != 0) @(negedge clk);
        check(wq_addr.size() == 0, rq, "command writes outstanding", wq_addr.size(), 0);
        if (kind != 2 && mode == 1'b0)
            check(m_rd == busy + 2, "R6", "data-poll read count", m_rd, busy + 2);
        if (kind != 2 && mode == 1'b1)
            check(m_rd >= busy + 2, "R7", "toggle read count", m_rd, busy + 2);
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check({fl_ce_n, fl_we_n, fl_oe_n} == 3'b111, "R1", "strobes in reset",
              {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        check(fl_dq_oe == 1'b0, "R1", "data drive in reset", fl_dq_oe, 0);
        check({rsp_done, rsp_error, rsp_timeout} == 3'b000, "R1", "responses in reset",
              {rsp_done, rsp_error, rsp_timeout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && fl_ce_n && fl_we_n && fl_oe_n, "R1", "idle after reset",
              {req_ready, fl_ce_n, fl_we_n, fl_oe_n}, 4'hF);

        // R2 R6 R8: program, data-poll, bit7 set
        run_op(2'd0, 1'b0, 19'h12345, 8'hA5, 4'h1, 5, 0, 0, 0, 0, "R8");
        // R6: program with bit7 clear
        run_op(2'd0, 1'b0, 19'h00010, 8'h3C, 4'h2, 3, 0, 0, 0, 0, "R6");
        // R6: immediate completion, race read then final read
        run_op(2'd0, 1'b0, 19'h7FFFF, 8'h80, 4'h3, 0, 0, 0, 0, 0, "R6");
        // R3: sector erase, data-poll
        run_op(2'd1, 1'b0, 19'h30000, 8'h00, 4'h4, 8, 0, 0, 0, 0, "R3");
        // R3 R7: chip erase, toggle mode
        run_op(2'd2, 1'b1, 19'h40000, 8'h00, 4'h5, 6, 0, 0, 0, 0, "R7");
        // R7: toggle mode ignores a bit 7 that claims completion early
        run_op(2'd0, 1'b1, 19'h01234, 8'h5A, 4'h6, 7, 0, 1, 0, 0, "R7");
        // R8: corrupted final byte, data-poll program
        run_op(2'd0, 1'b0, 19'h05555, 8'hC3, 4'h7, 2, 0, 0, 1, 1, "R8");
        // R8: corrupted final byte, toggle erase
        run_op(2'd1, 1'b1, 19'h10000, 8'h00, 4'h8, 4, 0, 0, 1, 1, "R8");
        // R9: device never finishes a program
        run_op(2'd0, 1'b0, 19'h22222, 8'h11, 4'h9, 0, 1, 0, 0, 2, "R9");
        // R9: erase never finishes, toggle mode
        run_op(2'd3, 1'b1, 19'h60000, 8'h00, 4'hA, 0, 1, 0, 0, 2, "R9");
        // R9 R10: normal operation after a timeout
        run_op(2'd0, 1'b0, 19'h00001, 8'h7E, 4'hB, 1, 0, 0, 0, 0, "R9");

        repeat (4) @(negedge clk);
        check(req_ready == 1'b1, "R10", "ready when idle", req_ready, 1);
        finish_up();
    end

endmodule